// File: doc/BRIEF.md
# Quadrature Sine DAC Sequencer

This block drives a four-channel serial DAC so that two differential pairs carry a sine and a cosine of the same frequency. Channel A carries the sine, channel B the inverted sine, channel C the cosine and channel D the inverted cosine. One shared table holds a single sine cycle of 32 samples. One phase pointer walks that table, and each channel reads it at its own fixed quarter-cycle offset.

A sample-rate tick from an external timer starts each frame. The block first pulses the DAC load strobe, so the four values sent in the previous frame update together. It then lowers chip-select and sends four 16-bit words, one per channel. Each word is framed by frame-sync and goes out as two bytes over a data line and a synchronous serial clock. After the last word the pointer advances by one sample and the block waits for the next tick. A tick that arrives while a frame is still in flight does nothing except raise a saturating overrun count.

Top module: `quad_sine_dac_seq`

## Requirements
- R1: While `rst` is sampled high on a rising clock edge, the block goes idle: `dac_cs_n`, `dac_fs_n` and `dac_ld_n` are high, `dac_sclk` is low, `overrun_cnt` is zero and the phase pointer is 0.
- R2: Table entry k (0..31) holds the 16-bit offset-binary value round(32768 + 32767·sin(2πk/32)).
- R3: Within a frame the words go out in the order A, B, C, D. Each reads the table entry at (pointer + offset) mod 32, with offset 0 for A, 16 for B, 8 for C and 24 for D.
- R4: The pointer rises by one after channel D's word and wraps from 31 to 0. The first frame after reset uses pointer 0.
- R5: An accepted tick drives `dac_ld_n` low from the next clock cycle for exactly LOAD_CYC cycles while `dac_cs_n` and `dac_fs_n` stay high. `dac_ld_n` never goes low without a tick.
- R6: `dac_cs_n` falls in the same cycle that `dac_ld_n` returns high. It rises after the fourth word, and each low period carries exactly four words.
- R7: `dac_fs_n` falls while `dac_cs_n` is low and before a word's first clock pulse. It rises after the word's 16th bit. Each word is 16 bits, most significant bit first: the high byte, then the low byte.
- R8: `dac_sclk` idles low whenever `dac_fs_n` is high. Each high phase lasts HALF_DIV clock cycles. `dac_sdo` changes only together with a rising `dac_sclk` and holds steady across each falling edge, which is where the receiver samples.
- R9: A tick sampled while a frame is in progress (load pulse through the end of word D) raises `overrun_cnt` by one, saturating at all ones, and has no other effect on the frame or the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample-rate request, one cycle wide |
| dac_ld_n | output | 1 | DAC load strobe, active low |
| dac_cs_n | output | 1 | DAC chip-select, active low |
| dac_fs_n | output | 1 | Per-word frame-sync, active low |
| dac_sclk | output | 1 | Serial clock, idle low |
| dac_sdo | output | 1 | Serial data, MSB first |
| overrun_cnt | output | OVR_W | Saturating count of ticks ignored while busy |

## Verification
The bench decodes the serial lines back into words and compares each word with a sine value it computes itself for the channel's offset. First it sends widely spaced ticks for more than one full table period, which shows the channel order and the pointer wrap. Next come random tick spacings, some shorter than a frame, which separate accepted ticks from overrun ticks and show that an ignored tick leaves the load pulse and the pointer alone. A burst of one tick per cycle drives the overrun count into saturation. A reset in the middle of a frame must return every line to idle and restart the table at entry 0.

// File: rtl/qsd_pkg.sv
package qsd_pkg;

  localparam int TBL_AW   = 5;
  localparam int TBL_N    = 1 << TBL_AW;
  localparam int SAMPLE_W = 16;
  localparam int BYTE_W   = 8;
  localparam int NUM_CH   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FS,
    ST_HI_GO,
    ST_HI_WAIT,
    ST_LO_GO,
    ST_LO_WAIT
  } seq_state_t;

  // Rounded amplitude of sin(k*pi/16) scaled to 32767, k = 0..8.
  function automatic int quarter_amp(input int k);
    case (k)
      0:       return 0;
      1:       return 6393;
      2:       return 12539;
      3:       return 18204;
      4:       return 23170;
      5:       return 27245;
      6:       return 30273;
      7:       return 32137;
      8:       return 32767;
      default: return 0;
    endcase
  endfunction

  // Offset-binary sample for table index idx, built by quarter-wave symmetry.
  function automatic logic [SAMPLE_W-1:0] sine_sample(input int idx);
    int p;
    int q;
    p = idx % (TBL_N / 2);
    q = (p > TBL_N / 4) ? (TBL_N / 2 - p) : p;
    if (((idx / (TBL_N / 2)) % 2) == 1)
      return SAMPLE_W'(32768 - quarter_amp(q));
    else
      return SAMPLE_W'(32768 + quarter_amp(q));
  endfunction

  // Phase offset per channel: A sine, B inverted sine, C cosine, D inverted cosine.
  function automatic logic [TBL_AW-1:0] chan_offset(input logic [1:0] ch);
    case (ch)
      2'd0:    return TBL_AW'(0);
      2'd1:    return TBL_AW'(TBL_N / 2);
      2'd2:    return TBL_AW'(TBL_N / 4);
      default: return TBL_AW'(3 * TBL_N / 4);
    endcase
  endfunction

endpackage

// File: rtl/qsd_sine_rom.sv
module qsd_sine_rom
  import qsd_pkg::*;
#(
  parameter int AW = TBL_AW,
  parameter int DW = SAMPLE_W
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    assign tbl[i] = DW'(sine_sample(i));
  end

  always_ff @(posedge clk) begin
    q <= tbl[addr];
  end

endmodule

// File: rtl/qsd_byte_tx.sv
module qsd_byte_tx
  import qsd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] din,
  output logic              done,
  output logic              sclk,
  output logic              sdo
);

  localparam int HW = $clog2(HALF_DIV + 1);
  localparam int BW = $clog2(BYTE_W);

  logic              busy;
  logic [HW-1:0]     half_cnt;
  logic [BW-1:0]     bit_idx;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy     <= 1'b0;
      half_cnt <= '0;
      bit_idx  <= '0;
      sh       <= '0;
      sclk     <= 1'b0;
      sdo      <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        sclk     <= 1'b1;
        sdo      <= din[BYTE_W-1];
        sh       <= {din[BYTE_W-2:0], 1'b0};
        bit_idx  <= '0;
        half_cnt <= '0;
      end
    end else if (half_cnt == HW'(HALF_DIV - 1)) begin
      half_cnt <= '0;
      if (sclk) begin
        sclk <= 1'b0;
      end else if (bit_idx == BW'(BYTE_W - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        sclk    <= 1'b1;
        sdo     <= sh[BYTE_W-1];
        sh      <= {sh[BYTE_W-2:0], 1'b0};
        bit_idx <= bit_idx + 1'b1;
      end
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/qsd_frame_ctrl.sv
module qsd_frame_ctrl
  import qsd_pkg::*;
#(
  parameter int LOAD_CYC = 2,
  parameter int OVR_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                tx_done,
  input  logic [SAMPLE_W-1:0] rom_q,
  output logic [TBL_AW-1:0]   rom_addr,
  output logic                tx_start,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic                ld_n,
  output logic                cs_n,
  output logic                fs_n,
  output logic [OVR_W-1:0]    overrun
);

  localparam int LC_W = $clog2(LOAD_CYC) + 1;
  localparam logic [OVR_W-1:0] OVR_MAX = '1;
  localparam logic [1:0] LAST_CH = 2'(NUM_CH - 1);

  seq_state_t        state;
  logic [TBL_AW-1:0] ptr;
  logic [1:0]        ch;
  logic [LC_W-1:0]   lcnt;
  logic [BYTE_W-1:0] lo_byte;

  assign rom_addr = ptr + chan_offset(ch);

  always_ff @(posedge clk) begin
    tx_start <= 1'b0;
    if (rst) begin
      state   <= ST_IDLE;
      ld_n    <= 1'b1;
      cs_n    <= 1'b1;
      fs_n    <= 1'b1;
      ptr     <= '0;
      ch      <= '0;
      lcnt    <= '0;
      tx_byte <= '0;
      lo_byte <= '0;
      overrun <= '0;
    end else begin
      if (tick && state != ST_IDLE && overrun != OVR_MAX)
        overrun <= overrun + 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (tick) begin
            ld_n  <= 1'b0;
            lcnt  <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (lcnt == LC_W'(LOAD_CYC - 1)) begin
            ld_n  <= 1'b1;
            cs_n  <= 1'b0;
            ch    <= '0;
            state <= ST_FS;
          end else begin
            lcnt <= lcnt + 1'b1;
          end
        end
        ST_FS: begin
          fs_n  <= 1'b0;
          state <= ST_HI_GO;
        end
        ST_HI_GO: begin
          tx_byte  <= rom_q[SAMPLE_W-1 -: BYTE_W];
          lo_byte  <= rom_q[BYTE_W-1:0];
          tx_start <= 1'b1;
          state    <= ST_HI_WAIT;
        end
        ST_HI_WAIT: begin
          if (tx_done) state <= ST_LO_GO;
        end
        ST_LO_GO: begin
          tx_byte  <= lo_byte;
          tx_start <= 1'b1;
          state    <= ST_LO_WAIT;
        end
        ST_LO_WAIT: begin
          if (tx_done) begin
            fs_n <= 1'b1;
            if (ch == LAST_CH) begin
              cs_n  <= 1'b1;
              ptr   <= ptr + 1'b1;
              state <= ST_IDLE;
            end else begin
              ch    <= ch + 1'b1;
              state <= ST_FS;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/quad_sine_dac_seq.sv
module quad_sine_dac_seq
  import qsd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LOAD_CYC = 2,
  parameter int OVR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic             dac_ld_n,
  output logic             dac_cs_n,
  output logic             dac_fs_n,
  output logic             dac_sclk,
  output logic             dac_sdo,
  output logic [OVR_W-1:0] overrun_cnt
);

  logic [TBL_AW-1:0]   rom_addr;
  logic [SAMPLE_W-1:0] rom_q;
  logic                tx_start;
  logic                tx_done;
  logic [BYTE_W-1:0]   tx_byte;

  qsd_sine_rom #(
    .AW(TBL_AW),
    .DW(SAMPLE_W)
  ) u_rom (
    .clk  (clk),
    .addr (rom_addr),
    .q    (rom_q)
  );

  qsd_frame_ctrl #(
    .LOAD_CYC(LOAD_CYC),
    .OVR_W   (OVR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .tx_done  (tx_done),
    .rom_q    (rom_q),
    .rom_addr (rom_addr),
    .tx_start (tx_start),
    .tx_byte  (tx_byte),
    .ld_n     (dac_ld_n),
    .cs_n     (dac_cs_n),
    .fs_n     (dac_fs_n),
    .overrun  (overrun_cnt)
  );

  qsd_byte_tx #(
    .HALF_DIV(HALF_DIV)
  ) u_tx (
    .clk   (clk),
    .rst   (rst),
    .start (tx_start),
    .din   (tx_byte),
    .done  (tx_done),
    .sclk  (dac_sclk),
    .sdo   (dac_sdo)
  );

endmodule

// File: rtl/quad_sine_dac_seq_chk.sv
module quad_sine_dac_seq_chk #(
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             dac_ld_n,
  input logic             dac_cs_n,
  input logic             dac_fs_n,
  input logic             dac_sclk,
  input logic             dac_sdo,
  input logic [OVR_W-1:0] overrun_cnt
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (dac_cs_n && dac_fs_n && dac_ld_n && !dac_sclk && overrun_cnt == '0));

  a_r5_load_outside_frame: assert property (@(posedge clk) disable iff (rst)
    !dac_ld_n |-> (dac_cs_n && dac_fs_n));

  a_r6_cs_follows_load: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_cs_n) |-> $rose(dac_ld_n));

  a_r7_fs_within_cs: assert property (@(posedge clk) disable iff (rst)
    !dac_fs_n |-> !dac_cs_n);

  a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    dac_fs_n |-> !dac_sclk);

  a_r8_data_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_sdo) |-> $rose(dac_sclk));

  a_r9_overrun_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(overrun_cnt) |-> ($past(tick) && overrun_cnt == $past(overrun_cnt) + 1'b1));

  a_r9_overrun_saturates: assert property (@(posedge clk) disable iff (rst)
    (&$past(overrun_cnt)) |-> (&overrun_cnt));

endmodule

bind quad_sine_dac_seq quad_sine_dac_seq_chk #(.OVR_W(OVR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .dac_ld_n    (dac_ld_n),
  .dac_cs_n    (dac_cs_n),
  .dac_fs_n    (dac_fs_n),
  .dac_sclk    (dac_sclk),
  .dac_sdo     (dac_sdo),
  .overrun_cnt (overrun_cnt)
);

// File: tb/quad_sine_dac_seq_tb.sv
`timescale 1ns/1ps
module quad_sine_dac_seq_tb;

  localparam int HALF_DIV = 2;
  localparam int LOAD_CYC = 2;
  localparam int OVR_W    = 8;
  localparam int OVR_MAX  = (1 << OVR_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic dac_ld_n, dac_cs_n, dac_fs_n, dac_sclk, dac_sdo;
  logic [OVR_W-1:0] overrun_cnt;

  always #10 clk = ~clk;

  quad_sine_dac_seq #(
    .HALF_DIV(HALF_DIV),
    .LOAD_CYC(LOAD_CYC),
    .OVR_W   (OVR_W)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .dac_ld_n    (dac_ld_n),
    .dac_cs_n    (dac_cs_n),
    .dac_fs_n    (dac_fs_n),
    .dac_sclk    (dac_sclk),
    .dac_sdo     (dac_sdo),
    .overrun_cnt (overrun_cnt)
  );

  int checks = 0;
  int fails  = 0;

  int ptr, ch, nbits, ld_run, hi_run, exp_ovr;
  logic [15:0] word;
  bit busy, exp_ld, rst_applied, tick_driven, finished;
  logic p_sclk, p_cs, p_fs, p_ld, sd_rise;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_word(input int p, input int c);
    int off;
    int k;
    case (c)
      0: off = 0;
      1: off = 16;
      2: off = 8;
      default: off = 24;
    endcase
    k = (p + off) % 32;
    return $rtoi(32768.0 + 32767.0 * $sin(2.0 * 3.14159265358979 * k / 32.0) + 0.5);
  endfunction

  task automatic model_reset();
    ptr = 0; ch = 0; nbits = 0; ld_run = 0; hi_run = 0; exp_ovr = 0;
    word = '0; busy = 0; exp_ld = 0;
  endtask

  task automatic monitor();
    if (rst_applied) begin
      // R1: idle state after a reset edge
      chk(dac_cs_n && dac_fs_n && dac_ld_n && !dac_sclk, "R1 idle lines",
          {dac_cs_n, dac_fs_n, dac_ld_n, dac_sclk}, 4'b1110);
      chk(overrun_cnt == 0, "R1 overrun cleared", overrun_cnt, 0);
      model_reset();
    end else begin
      // R5: load strobe
      if (exp_ld) begin
        chk(!dac_ld_n, "R5 load low after tick", dac_ld_n, 0);
        exp_ld = 0;
      end
      if (p_ld && !dac_ld_n) begin
        chk(busy, "R5 load only after tick", busy, 1);
        chk(dac_cs_n && dac_fs_n, "R5 cs/fs high in load", {dac_cs_n, dac_fs_n}, 2'b11);
      end
      if (!dac_ld_n) ld_run = p_ld ? 1 : ld_run + 1;
      if (!p_ld && dac_ld_n) chk(ld_run == LOAD_CYC, "R5 load width", ld_run, LOAD_CYC);
      // R6: chip-select
      if (p_cs && !dac_cs_n) begin
        chk(!p_ld && dac_ld_n, "R6 cs falls as load ends", {p_ld, dac_ld_n}, 2'b01);
        ch = 0;
      end
      // R7: frame-sync start
      if (p_fs && !dac_fs_n) begin
        chk(!dac_cs_n, "R7 fs inside cs", dac_cs_n, 0);
        nbits = 0;
        word = '0;
      end
      // R8: serial clock and data
      if (!p_sclk && dac_sclk) begin
        chk(!dac_fs_n && !dac_cs_n, "R7 sclk inside word", {dac_cs_n, dac_fs_n}, 0);
        sd_rise = dac_sdo;
      end
      if (dac_sclk) hi_run = p_sclk ? hi_run + 1 : 1;
      if (p_sclk && !dac_sclk) begin
        chk(hi_run == HALF_DIV, "R8 high phase width", hi_run, HALF_DIV);
        chk(dac_sdo == sd_rise, "R8 data stable across high phase", dac_sdo, sd_rise);
        word = {word[14:0], dac_sdo};
        nbits++;
      end
      // R7 word length, R2/R3/R4 word content
      if (!p_fs && dac_fs_n) begin
        chk(nbits == 16, "R7 bits per word", nbits, 16);
        chk(int'(word) == ref_word(ptr, ch), $sformatf("R2/R3/R4 word ch%0d ptr%0d", ch, ptr),
            word, ref_word(ptr, ch));
        ch++;
      end
      if (!p_cs && dac_cs_n) begin
        chk(ch == 4, "R6 words per frame", ch, 4);
        ptr = (ptr + 1) % 32;   // R4 wrap at 32
        busy = 0;
      end
      // R9: overrun count after any tick
      if (tick_driven) chk(int'(overrun_cnt) == exp_ovr, "R9 overrun count", overrun_cnt, exp_ovr);
    end
    p_sclk = dac_sclk; p_cs = dac_cs_n; p_fs = dac_fs_n; p_ld = dac_ld_n;
  endtask

  task automatic step(input bit t, input bit r);
    @(negedge clk);
    monitor();
    rst = r;
    rst_applied = r;
    tick_driven = t && !r;
    if (t && !r) begin
      if (busy) begin
        if (exp_ovr < OVR_MAX) exp_ovr++;
      end else begin
        busy = 1;
        exp_ld = 1;
      end
    end
    tick = t && !r;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    int gap;
    finished = 0;
    rst_applied = 1;
    tick_driven = 0;
    p_sclk = 0; p_cs = 1; p_fs = 1; p_ld = 1; sd_rise = 0;
    model_reset();
    void'($urandom(32'd20061));

    repeat (4) step(0, 1);
    step(0, 0);

    // Directed: widely spaced ticks over more than one table period (R3, R4)
    for (int i = 0; i < 34; i++) begin
      step(1, 0);
      repeat (399) step(0, 0);
    end

    // Random spacing, some shorter than a frame (R9)
    for (int i = 0; i < 80; i++) begin
      gap = int'($urandom_range(1, 450));
      step(1, 0);
      repeat (gap) step(0, 0);
    end
    repeat (400) step(0, 0);

    // Tick every cycle: overrun saturation (R9)
    repeat (700) step(1, 0);
    repeat (400) step(0, 0);
    chk(int'(overrun_cnt) == OVR_MAX, "R9 saturated count", overrun_cnt, OVR_MAX);

    // Reset in the middle of a frame, then restart from entry 0 (R1, R4)
    step(1, 0);
    repeat (100) step(0, 0);
    repeat (2) step(0, 1);
    step(0, 0);
    step(1, 0);
    repeat (400) step(0, 0);
    chk(int'(overrun_cnt) == exp_ovr, "R9 final overrun", overrun_cnt, exp_ovr);

    summary();
    $finish;
  end

endmodule